// File: doc/BRIEF.md
# Size-Merging Processor Register File

This block stores the working registers of a processor core. There are eight data registers and eight address registers. Address index 7 is the stack pointer. It is backed by two physical registers, a user copy and a supervisor copy, and a select input picks which one is used. Every request carries an operation size of byte, word or long. The rules for partial writes depend on the register class. A data register keeps every bit above the written portion. An address register is always replaced in full, and a word source is sign-extended to the register width first.

There are two independent read ports and one write port. Each read port returns the operand in two forms: zero-extended on one output and sign-extended on the other. A read of the register being written in the same cycle returns the value that register will hold after the clock edge. Each port has a combinational error flag. The flag marks a request that the block refuses: a byte-size access to an address register, or the reserved size code.

Top module: `sized_regfile`

## Requirements
- R1: A synchronous reset, active high, sets every data register and both stack-pointer copies to zero.
- R2: Size code 2'b00 is byte (bits 7:0), 2'b01 is word (bits 15:0), 2'b10 is long (all 32 bits), and 2'b11 is reserved. A reserved-size write raises wr_err and changes no register. A reserved-size read raises that port's error flag and returns zero on both outputs.
- R3: A byte or word write to a data register replaces only bits 7:0 or 15:0 and leaves all higher bits unchanged. A long write replaces all 32 bits.
- R4: A word write to an address register stores the 16-bit source sign-extended to 32 bits. A long write stores the full source.
- R5: A byte write to an address register raises wr_err in the same cycle and leaves the register unchanged.
- R6: A byte or word read drives the operand zero-extended on rdN_data and sign-extended on rdN_sext. A long read drives the full register on both outputs.
- R7: A byte read of an address register raises that port's error flag and drives zero on both of its outputs.
- R8: Address index 7 reaches the user stack pointer when sp_sel is 0 and the supervisor stack pointer when sp_sel is 1, for both reads and writes. The unselected copy is untouched.
- R9: A read that targets the register accepted for writing in the same cycle returns the value written. A refused write does not bypass.
- R10: The two read ports operate independently and may address any registers, sizes and classes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sp_sel | input | 1 | Stack pointer copy for address index 7 (0 user, 1 supervisor) |
| wr_en | input | 1 | Write request |
| wr_areg | input | 1 | Write class: 0 data, 1 address |
| wr_idx | input | 3 | Write register index |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write source operand |
| wr_err | output | 1 | Write request refused |
| rd0_areg | input | 1 | Port 0 class |
| rd0_idx | input | 3 | Port 0 register index |
| rd0_size | input | 2 | Port 0 size code |
| rd0_data | output | 32 | Port 0 operand, zero-extended |
| rd0_sext | output | 32 | Port 0 operand, sign-extended |
| rd0_err | output | 1 | Port 0 request refused |
| rd1_areg | input | 1 | Port 1 class |
| rd1_idx | input | 3 | Port 1 register index |
| rd1_size | input | 2 | Port 1 size code |
| rd1_data | output | 32 | Port 1 operand, zero-extended |
| rd1_sext | output | 32 | Port 1 operand, sign-extended |
| rd1_err | output | 1 | Port 1 request refused |

## Verification
The bench uses the default parameters: a 32-bit width and eight registers per class. With these values, index 7 is the stack pointer, so both copies and the sp_sel switch can be tested directly. Bit 7 and bit 15 are the sign positions that separate rdN_data from rdN_sext, and they also separate a merged data write from a sign-extended address write. A random phase draws indices from the small index space, so same-cycle bypass hits and collisions between the two read ports occur often.

// File: rtl/sized_regfile.sv
`timescale 1ns/1ps
module sized_regfile #(
  parameter int DW = 32,
  parameter int NR = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sp_sel,
  input  logic          wr_en,
  input  logic          wr_areg,
  input  logic [$clog2(NR)-1:0] wr_idx,
  input  logic [1:0]    wr_size,
  input  logic [DW-1:0] wr_data,
  output logic          wr_err,
  input  logic          rd0_areg,
  input  logic [$clog2(NR)-1:0] rd0_idx,
  input  logic [1:0]    rd0_size,
  output logic [DW-1:0] rd0_data,
  output logic [DW-1:0] rd0_sext,
  output logic          rd0_err,
  input  logic          rd1_areg,
  input  logic [$clog2(NR)-1:0] rd1_idx,
  input  logic [1:0]    rd1_size,
  output logic [DW-1:0] rd1_data,
  output logic [DW-1:0] rd1_sext,
  output logic          rd1_err
);
  localparam int IW = $clog2(NR);
  localparam int NA = NR + 1;

  logic [DW-1:0] dq [NR];
  logic [DW-1:0] aq [NA];

  function automatic logic [IW:0] aslot(input logic [IW-1:0] i, input logic s);
    return (i == IW'(NR-1)) ? ((IW+1)'(NR-1) + (IW+1)'(s)) : {1'b0, i};
  endfunction

  function automatic logic bad_req(input logic a, input logic [1:0] s);
    return (s == 2'b11) || (a && s == 2'b00);
  endfunction

  function automatic logic [DW-1:0] zx(input logic [DW-1:0] v, input logic [1:0] s);
    case (s)
      2'b00:   return {{(DW-8){1'b0}}, v[7:0]};
      2'b01:   return {{(DW-16){1'b0}}, v[15:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic [DW-1:0] sx(input logic [DW-1:0] v, input logic [1:0] s);
    case (s)
      2'b00:   return {{(DW-8){v[7]}}, v[7:0]};
      2'b01:   return {{(DW-16){v[15]}}, v[15:0]};
      default: return v;
    endcase
  endfunction

  logic [IW:0]   wslot;
  logic          wr_go;
  logic [DW-1:0] wold, wnew;

  assign wslot  = aslot(wr_idx, sp_sel);
  assign wr_err = wr_en && bad_req(wr_areg, wr_size);
  assign wr_go  = wr_en && !bad_req(wr_areg, wr_size);
  assign wold   = wr_areg ? aq[wslot] : dq[wr_idx];

  always_comb begin
    case (wr_size)
      2'b00:   wnew = {wold[DW-1:8], wr_data[7:0]};
      2'b01:   wnew = wr_areg ? {{(DW-16){wr_data[15]}}, wr_data[15:0]}
                              : {wold[DW-1:16], wr_data[15:0]};
      default: wnew = wr_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) dq[i] <= '0;
      for (int i = 0; i < NA; i++) aq[i] <= '0;
    end else if (wr_go) begin
      if (wr_areg) aq[wslot] <= wnew;
      else         dq[wr_idx] <= wnew;
    end
  end

  logic [DW-1:0] raw0, raw1;
  logic          hit0, hit1;

  assign hit0 = wr_go && (rd0_areg == wr_areg) &&
                (rd0_areg ? (aslot(rd0_idx, sp_sel) == wslot) : (rd0_idx == wr_idx));
  assign hit1 = wr_go && (rd1_areg == wr_areg) &&
                (rd1_areg ? (aslot(rd1_idx, sp_sel) == wslot) : (rd1_idx == wr_idx));

  assign raw0 = hit0 ? wnew : (rd0_areg ? aq[aslot(rd0_idx, sp_sel)] : dq[rd0_idx]);
  assign raw1 = hit1 ? wnew : (rd1_areg ? aq[aslot(rd1_idx, sp_sel)] : dq[rd1_idx]);

  assign rd0_err  = bad_req(rd0_areg, rd0_size);
  assign rd1_err  = bad_req(rd1_areg, rd1_size);
  assign rd0_data = rd0_err ? '0 : zx(raw0, rd0_size);
  assign rd0_sext = rd0_err ? '0 : sx(raw0, rd0_size);
  assign rd1_data = rd1_err ? '0 : zx(raw1, rd1_size);
  assign rd1_sext = rd1_err ? '0 : sx(raw1, rd1_size);
endmodule

// File: rtl/sized_regfile_chk.sv
`timescale 1ns/1ps
module sized_regfile_chk #(
  parameter int DW = 32,
  parameter int NR = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sp_sel,
  input logic          wr_en,
  input logic          wr_areg,
  input logic [$clog2(NR)-1:0] wr_idx,
  input logic [1:0]    wr_size,
  input logic [15:0]   wd_lo,
  input logic          wr_err,
  input logic [1:0]    rd0_size,
  input logic [DW-1:0] rd0_data,
  input logic [DW-1:0] rd0_sext,
  input logic          rd0_err,
  input logic [DW-1:0] dq [NR],
  input logic [DW-1:0] aq [NR+1]
);
  localparam int IW = $clog2(NR);
  logic [IW:0] ws;
  always_comb begin
    if (wr_idx == IW'(NR-1)) ws = sp_sel ? (IW+1)'(NR) : (IW+1)'(NR-1);
    else ws = {1'b0, wr_idx};
  end

  assert_dlow_merge_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en && !wr_areg && wr_size == 2'b00 |=>
      dq[$past(wr_idx)] == {$past(dq[wr_idx][DW-1:8]), $past(wd_lo[7:0])});

  assert_aword_sext_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_areg && wr_size == 2'b01 |=>
      aq[$past(ws)] == {{(DW-16){$past(wd_lo[15])}}, $past(wd_lo)});

  assert_abyte_flag_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_areg && wr_size == 2'b00 |-> wr_err);

  assert_abyte_keep_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_areg && wr_size == 2'b00 |=> aq[$past(ws)] == $past(aq[ws]));

  assert_rd_err_zero_R7: assert property (@(posedge clk) disable iff (rst)
    rd0_err |-> rd0_data == '0 && rd0_sext == '0);

  assert_rd_zext_R6: assert property (@(posedge clk) disable iff (rst)
    !rd0_err && rd0_size == 2'b00 |-> rd0_data[DW-1:8] == '0);
endmodule

bind sized_regfile sized_regfile_chk #(.DW(DW), .NR(NR)) u_chk (
  .clk(clk), .rst(rst), .sp_sel(sp_sel), .wr_en(wr_en), .wr_areg(wr_areg),
  .wr_idx(wr_idx), .wr_size(wr_size), .wd_lo(wr_data[15:0]), .wr_err(wr_err),
  .rd0_size(rd0_size), .rd0_data(rd0_data), .rd0_sext(rd0_sext), .rd0_err(rd0_err),
  .dq(dq), .aq(aq)
);

// File: tb/sized_regfile_bench.sv
`timescale 1ns/1ps
module sized_regfile_bench;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst, sp_sel, wr_en, wr_areg, wr_err;
  logic [2:0] wr_idx, rd0_idx, rd1_idx;
  logic [1:0] wr_size, rd0_size, rd1_size;
  logic [31:0] wr_data, rd0_data, rd0_sext, rd1_data, rd1_sext;
  logic rd0_areg, rd1_areg, rd0_err, rd1_err;

  sized_regfile u_sized_regfile (
    .clk(clk), .rst(rst), .sp_sel(sp_sel), .wr_en(wr_en), .wr_areg(wr_areg),
    .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data), .wr_err(wr_err),
    .rd0_areg(rd0_areg), .rd0_idx(rd0_idx), .rd0_size(rd0_size),
    .rd0_data(rd0_data), .rd0_sext(rd0_sext), .rd0_err(rd0_err),
    .rd1_areg(rd1_areg), .rd1_idx(rd1_idx), .rd1_size(rd1_size),
    .rd1_data(rd1_data), .rd1_sext(rd1_sext), .rd1_err(rd1_err));

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] md [8], ma [9], nd [8], na [9];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit refused(logic a, logic [1:0] s);
    return s == 2'd3 || (a && s == 2'd0);
  endfunction

  function automatic int slot(logic [2:0] i, logic s);
    return (i == 3'd7) ? 7 + int'(s) : int'(i);
  endfunction

  function automatic logic [31:0] view(logic a, logic [2:0] i, logic [1:0] s, bit sg);
    logic [31:0] v;
    if (refused(a, s)) return 0;
    v = a ? na[slot(i, sp_sel)] : nd[i];
    if (s == 2'd0) return sg ? 32'($signed(v[7:0])) : 32'(v[7:0]);
    if (s == 2'd1) return sg ? 32'($signed(v[15:0])) : 32'(v[15:0]);
    return v;
  endfunction

  task automatic op(string tag, logic sp, logic we, logic wa, logic [2:0] wi,
                    logic [1:0] wsz, logic [31:0] wd,
                    logic r0a, logic [2:0] r0i, logic [1:0] r0s,
                    logic r1a, logic [2:0] r1i, logic [1:0] r1s);
    @(negedge clk);
    sp_sel = sp; wr_en = we; wr_areg = wa; wr_idx = wi; wr_size = wsz; wr_data = wd;
    rd0_areg = r0a; rd0_idx = r0i; rd0_size = r0s;
    rd1_areg = r1a; rd1_idx = r1i; rd1_size = r1s;
    nd = md; na = ma;
    if (we && !refused(wa, wsz)) begin
      if (wa) na[slot(wi, sp)] = (wsz == 2'd1) ? 32'($signed(wd[15:0])) : wd;
      else if (wsz == 2'd0) nd[wi][7:0] = wd[7:0];
      else if (wsz == 2'd1) nd[wi][15:0] = wd[15:0];
      else nd[wi] = wd;
    end
    #1;
    chk(tag, "wr_err", 32'(wr_err), 32'(we && refused(wa, wsz)));
    chk(tag, "rd0_err", 32'(rd0_err), 32'(refused(r0a, r0s)));
    chk(tag, "rd1_err", 32'(rd1_err), 32'(refused(r1a, r1s)));
    chk(tag, "rd0_data", rd0_data, view(r0a, r0i, r0s, 0));
    chk(tag, "rd0_sext", rd0_sext, view(r0a, r0i, r0s, 1));
    chk(tag, "rd1_data", rd1_data, view(r1a, r1i, r1s, 0));
    chk(tag, "rd1_sext", rd1_sext, view(r1a, r1i, r1s, 1));
    @(posedge clk);
    md = nd; ma = na;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; wr_en = 0;
    @(posedge clk); @(posedge clk);
    foreach (md[i]) md[i] = 0;
    foreach (ma[i]) ma[i] = 0;
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; sp_sel = 0; wr_en = 0; wr_areg = 0; wr_idx = 0; wr_size = 0; wr_data = 0;
    rd0_areg = 0; rd0_idx = 0; rd0_size = 2; rd1_areg = 0; rd1_idx = 0; rd1_size = 2;
    do_reset();

    op("R1", 0, 1, 0, 3'd3, 2'd2, 32'h12345678, 0, 0, 2, 0, 0, 2);
    op("R1", 1, 1, 1, 3'd7, 2'd2, 32'hCAFEF00D, 0, 0, 2, 0, 0, 2);
    do_reset();
    for (int i = 0; i < 8; i++) begin
      op("R1", 0, 0, 0, 0, 0, 0, 0, 3'(i), 2'd2, 1, 3'(i), 2'd2);
      op("R1", 1, 0, 0, 0, 0, 0, 1, 3'd7, 2'd2, 1, 3'(i), 2'd2);
    end

    op("R3", 0, 1, 0, 3'd1, 2'd2, 32'hAABBCCDD, 0, 1, 2, 0, 1, 2);
    op("R3", 0, 1, 0, 3'd1, 2'd0, 32'hFFFFFF91, 0, 1, 2, 0, 1, 2);
    op("R3", 0, 1, 0, 3'd1, 2'd1, 32'h0000A233, 0, 1, 2, 0, 1, 2);
    op("R6", 0, 0, 0, 0, 0, 0, 0, 3'd1, 2'd0, 0, 3'd1, 2'd1);
    op("R6", 0, 1, 0, 3'd2, 2'd2, 32'h00807F7F, 0, 2, 0, 0, 2, 1);

    op("R4", 0, 1, 1, 3'd3, 2'd1, 32'h12348001, 1, 3, 2, 1, 3, 1);
    op("R4", 0, 1, 1, 3'd3, 2'd1, 32'hFFFF7FFF, 1, 3, 2, 1, 3, 1);
    op("R4", 0, 1, 1, 3'd4, 2'd2, 32'h87654321, 1, 4, 2, 1, 4, 1);

    op("R5", 0, 1, 1, 3'd3, 2'd0, 32'h000000EE, 1, 3, 2, 1, 3, 2);
    op("R5", 0, 0, 0, 0, 0, 0, 1, 3, 2, 0, 0, 2);

    op("R2", 0, 1, 0, 3'd1, 2'd3, 32'h55555555, 0, 1, 2, 0, 1, 3);
    op("R2", 0, 1, 1, 3'd4, 2'd3, 32'h55555555, 1, 4, 2, 1, 4, 3);

    op("R7", 0, 0, 0, 0, 0, 0, 1, 4, 0, 1, 3, 0);

    op("R8", 0, 1, 1, 3'd7, 2'd2, 32'h1111AAAA, 1, 7, 2, 1, 7, 2);
    op("R8", 1, 1, 1, 3'd7, 2'd1, 32'h0000C0DE, 1, 7, 2, 1, 7, 1);
    op("R8", 0, 0, 0, 0, 0, 0, 1, 7, 2, 1, 7, 1);
    op("R8", 1, 0, 0, 0, 0, 0, 1, 7, 2, 1, 7, 1);

    op("R9", 0, 1, 0, 3'd5, 2'd2, 32'hDEADBEEF, 0, 5, 2, 0, 5, 0);
    op("R9", 0, 1, 0, 3'd5, 2'd0, 32'h00000042, 0, 5, 2, 0, 4, 2);
    op("R9", 1, 1, 1, 3'd7, 2'd1, 32'h0000F00F, 1, 7, 2, 0, 7, 2);
    op("R9", 0, 1, 1, 3'd2, 2'd0, 32'h000000FF, 1, 2, 2, 1, 2, 1);
    op("R9", 0, 1, 0, 3'd5, 2'd3, 32'h77777777, 0, 5, 2, 0, 5, 1);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      op("R10", r[0], r[1], r[2], r[5:3], r[7:6], $urandom,
         r[8], r[11:9], r[13:12], r[14], r[17:15], r[19:18]);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule